// File: doc/BRIEF.md
# Seconds Countdown Alarm with Interrupt and Wake Outputs

This block is a relative alarm. Software loads an unsigned count of seconds through a small register bus. While the alarm is enabled, every pulse on the seconds tick input takes one from the remaining count. The remaining count can be read back at any time. When the count steps from one to zero, a sticky pending flag is raised and the count stays at zero.

The pending flag drives two outputs. The interrupt output is high while the flag is set and interrupts are enabled. The wake output is high while the flag is set and the wake option is configured. Software clears the flag by writing a one to it. To reprogram the alarm safely, software disables the alarm and clears the flag, writes zero to the load register, waits, writes the new count, and then enables the alarm again.

The register bus is plain control access with no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. A read is combinational from `bus_addr`. Registers are word-indexed: 0 load, 1 remaining (read only), 2 enable, 3 interrupt enable, 4 status, 5 wake config. Unused addresses read as zero.

Top module: `countdown_alarm`

## Requirements
- R1: After reset, every register reads 0, and `irq` and `wake` are low.
- R2: A write to address 0 sets the remaining count to the written value from the next cycle on. Address 0 reads back the last value written to it.
- R3: While bit 0 of address 2 is 1, each cycle with `sec_tick` high lowers the remaining count (address 1) by one. While that bit is 0, ticks leave the count unchanged.
- R4: A step from 1 to 0 sets the pending flag (address 4, bit 0). The count then stays at 0 under further ticks, and those ticks do not set the flag again.
- R5: Writing address 4 with bit 0 = 1 clears the pending flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R6: If a clear write and an expiry fall in the same cycle, the flag is set afterwards.
- R7: `irq` is high exactly when the pending flag is set and bit 0 of address 3 is 1.
- R8: `wake` is high exactly when the pending flag is set and bit 0 of address 5 is 1.
- R9: A load write in the same cycle as a counting tick takes the written value, and that tick is not applied.
- R10: Writing 0 to address 0 cancels the countdown, and no expiry follows from later ticks.
- R11: Address 1 is read only: a write to it leaves the remaining count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| sec_tick | input | 1 | One-cycle seconds pulse |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
Two pairs of events can land in the same cycle. The first pair is an expiry and a software clear of the flag. The second pair is a load and a counting tick. The first pair is provoked by loading 1 with the alarm enabled, then issuing the status clear in the cycle that carries the tick. The flag and `irq` must stay high. The second pair is provoked by loading with a tick present, and the read-back must show the written value, not that value minus one. Random traffic with small load values and frequent clears also produces both collisions, and each result is compared with an independent cycle model in the bench.

// File: rtl/alm_pkg.sv
package alm_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_LOAD   = 3'd0;
  localparam logic [ADDR_W-1:0] A_REMAIN = 3'd1;
  localparam logic [ADDR_W-1:0] A_EN     = 3'd2;
  localparam logic [ADDR_W-1:0] A_IE     = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd4;
  localparam logic [ADDR_W-1:0] A_WAKE   = 3'd5;
  localparam int N_CTRL = 3;
  // control bits in order: enable, interrupt enable, wake config
  localparam logic [N_CTRL*ADDR_W-1:0] CTRL_ADDRS = {A_WAKE, A_IE, A_EN};
endpackage

// File: rtl/alm_regs.sv
module alm_regs
  import alm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [CNT_W-1:0]  remain,
  input  logic              pending,
  output logic [CNT_W-1:0]  rdata,
  output logic              load_we,
  output logic [CNT_W-1:0]  load_val,
  output logic              clr,
  output logic [N_CTRL-1:0] ctrl
);
  logic [CNT_W-1:0] load_q;

  assign load_we  = wr && (addr == A_LOAD);
  assign load_val = wdata;
  assign clr      = wr && (addr == A_STAT) && wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n)       load_q <= '0;
    else if (load_we) load_q <= wdata;
  end

  for (genvar i = 0; i < N_CTRL; i++) begin : g_ctrl
    always_ff @(posedge clk) begin
      if (!rst_n) ctrl[i] <= 1'b0;
      else if (wr && addr == CTRL_ADDRS[i*ADDR_W +: ADDR_W]) ctrl[i] <= wdata[0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_LOAD:   rdata = load_q;
      A_REMAIN: rdata = remain;
      A_EN:     rdata[0] = ctrl[0];
      A_IE:     rdata[0] = ctrl[1];
      A_STAT:   rdata[0] = pending;
      A_WAKE:   rdata[0] = ctrl[2];
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/alm_counter.sv
module alm_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_we,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  input  logic             tick,
  output logic [CNT_W-1:0] remain,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic step;
  assign step   = en && tick && !load_we && (remain != '0);
  assign expire = step && (remain == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n)       remain <= '0;
    else if (load_we) remain <= load_val;
    else if (step)    remain <= remain - ONE;
  end

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_we && en && tick && remain != '0) |=> remain == $past(remain) - ONE);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_we && !(en && tick)) |=> $stable(remain));
  a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_we && remain == '0) |=> remain == '0);
  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_we |=> remain == $past(load_val));
endmodule

// File: rtl/alm_flag.sv
module alm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  input  logic irq_en,
  input  logic wake_en,
  output logic pending,
  output logic irq,
  output logic wake
);
  always_ff @(posedge clk) begin
    if (!rst_n)      pending <= 1'b0;
    else if (expire) pending <= 1'b1;
    else if (clr)    pending <= 1'b0;
  end

  assign irq  = pending && irq_en;
  assign wake = pending && wake_en;

  a_r6_expiry_wins: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pending);
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !expire) |=> !pending);
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!expire && !clr) |=> pending == $past(pending));
endmodule

// File: rtl/countdown_alarm.sv
module countdown_alarm
  import alm_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             sec_tick,
  output logic             irq,
  output logic             wake
);
  logic             load_we, clr, expire, pending;
  logic [CNT_W-1:0] load_val, remain;
  logic [N_CTRL-1:0] ctrl;

  alm_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .remain(remain), .pending(pending), .rdata(bus_rdata),
    .load_we(load_we), .load_val(load_val), .clr(clr), .ctrl(ctrl)
  );

  alm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_val(load_val),
    .en(ctrl[0]), .tick(sec_tick), .remain(remain), .expire(expire)
  );

  alm_flag u_flag (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clr(clr),
    .irq_en(ctrl[1]), .wake_en(ctrl[2]), .pending(pending), .irq(irq), .wake(wake)
  );
endmodule

// File: tb/countdown_alarm_bench.sv
`timescale 1ns/100ps
module countdown_alarm_bench;
  localparam real HALF = 2.5;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, sec_tick = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, wake;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(HALF) clk = ~clk;

  countdown_alarm u_countdown_alarm (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_tick(sec_tick),
    .irq(irq), .wake(wake)
  );

  // bench model of the register state
  logic [31:0] m_load = 0, m_rem = 0;
  logic m_en = 0, m_ie = 0, m_wk = 0, m_pend = 0;

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_load;
      3'd1: return m_rem;
      3'd2: return {31'b0, m_en};
      3'd3: return {31'b0, m_ie};
      3'd4: return {31'b0, m_pend};
      3'd5: return {31'b0, m_wk};
      default: return 32'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d,
                      input logic tk, input string tag);
    logic ld, ex;
    @(negedge clk);
    bus_wr = w; bus_addr = a; bus_wdata = d; sec_tick = tk;
    ld = w && a == 3'd0;
    ex = m_en && tk && !ld && m_rem == 32'd1;
    if (ld) begin m_rem = d; m_load = d; end
    else if (m_en && tk && m_rem != 0) m_rem = m_rem - 1;
    if (ex) m_pend = 1'b1;
    else if (w && a == 3'd4 && d[0]) m_pend = 1'b0;
    if (w && a == 3'd2) m_en = d[0];
    if (w && a == 3'd3) m_ie = d[0];
    if (w && a == 3'd5) m_wk = d[0];
    @(posedge clk); #1;
    bus_wr = 1'b0; sec_tick = 1'b0;
    chk({tag, " R7 irq"}, {31'b0, irq}, {31'b0, m_pend & m_ie});
    chk({tag, " R8 wake"}, {31'b0, wake}, {31'b0, m_pend & m_wk});
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    bus_addr = a; #0.5;
    chk(tag, bus_rdata, exp_rd(a));
  endtask

  initial begin
    #(2.0 * HALF * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    done = 1;
  end

  initial begin
    int unsigned seed = 32'd1234;
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), "R1 reset read");
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 wake", {31'b0, wake}, 0);
    // R2 load and readback
    step(1, 3'd0, 32'd5, 0, "R2");
    rd(3'd0, "R2 load readback"); rd(3'd1, "R2 remain");
    // R11 remaining is read only
    step(1, 3'd1, 32'h123, 0, "R11");
    rd(3'd1, "R11 remain unchanged");
    // R3 ticks ignored while disabled
    step(0, 0, 0, 1, "R3"); step(0, 0, 0, 1, "R3");
    rd(3'd1, "R3 disabled hold");
    step(1, 3'd2, 32'd1, 0, "R3");
    step(0, 0, 0, 1, "R3"); step(0, 0, 0, 0, "R3"); step(0, 0, 0, 1, "R3");
    rd(3'd1, "R3 count down");
    chk("R3 value", bus_rdata, 32'd3);
    // R7/R8 enables, then expiry R4
    step(1, 3'd3, 32'd1, 0, "R7"); step(1, 3'd5, 32'd1, 0, "R8");
    repeat (3) step(0, 0, 0, 1, "R4");
    rd(3'd4, "R4 pending set");
    chk("R4 flag", bus_rdata, 32'd1);
    chk("R7 irq high", {31'b0, irq}, 1);
    chk("R8 wake high", {31'b0, wake}, 1);
    repeat (2) step(0, 0, 0, 1, "R4");
    rd(3'd1, "R4 stays zero");
    // R5 clear semantics
    step(1, 3'd4, 32'd0, 0, "R5");
    rd(3'd4, "R5 write zero no effect");
    step(1, 3'd4, 32'd1, 0, "R5");
    rd(3'd4, "R5 cleared");
    repeat (2) step(0, 0, 0, 1, "R4");
    rd(3'd4, "R4 no second set");
    // R6 expiry beats clear
    step(1, 3'd0, 32'd1, 0, "R6");
    step(1, 3'd4, 32'd1, 1, "R6");
    rd(3'd4, "R6 expiry wins");
    chk("R6 irq", {31'b0, irq}, 1);
    step(1, 3'd4, 32'd1, 0, "R6");
    // R9 load same cycle as tick
    step(1, 3'd0, 32'd3, 1, "R9");
    rd(3'd1, "R9 load wins");
    chk("R9 value", bus_rdata, 32'd3);
    // R10 cancel by zero
    step(1, 3'd0, 32'd0, 0, "R10");
    repeat (4) step(0, 0, 0, 1, "R10");
    rd(3'd4, "R10 no expiry"); rd(3'd1, "R10 zero");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      logic [31:0] d;
      logic w;
      w = ($urandom % 4) == 0;
      a = 3'($urandom % 7);
      d = (a == 3'd0) ? ($urandom % 6) : ($urandom % 2);
      step(w, a, d, ($urandom % 2) == 1, "R3 rand");
      rd(3'($urandom % 7), "R3 rand read");
    end
    done = 1;
  end

  initial begin
    wait (done);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule